// File: doc/BRIEF.md
# Bus-Master Register Window for a Two-Channel Disk Controller

This block decodes the small I/O window that software uses to reach the per-channel bus-master registers of a disk controller with two channels. Each channel owns an eight-byte group. The low four bytes of the group hold that channel's command byte, an alias of the controller-wide mode/mask byte, the channel's status byte and its transfer-timing byte. The high four bytes belong to the descriptor-address port, which sits outside this block. The block only flags accesses to those bytes on a select output.

Only single-byte accesses change state. Wider writes are dropped. Wider reads return all ones for the width of the access. Reads come back one cycle after the strobe.

The status byte mixes three kinds of bit:
- plain read/write bits;
- a bit that software cannot change;
- write-one-to-clear flags that the DMA engine sets through side inputs.

A write to the mode alias does not store anything here. It sends the merged new value, with a one-cycle strobe, to the interrupt unit that owns the register.

Top module: `bmw_window`

## Requirements
- R1: After reset every command, timing and status byte is 0x00, and rd_data, rd_valid and mode_wr are 0.
- R2: Address bits [ADDR_W-1:3] select the channel and bit 2 selects its descriptor half. An access (read or write, any size) with bit 2 set drives desc_sel[channel] high in the same cycle and changes no register here. A byte read there returns 0x000000FF.
- R3: Access size is coded as 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. A write of any size other than one byte changes nothing. A read of any size other than one byte returns 0x0000FFFF for code 1 and 0xFFFFFFFF for codes 2 and 3.
- R4: rd_valid is high exactly in the cycle after acc_rd is sampled, and rd_data then holds the value read. A byte read is zero-extended to 32 bits and reflects the register contents before any update in the same cycle.
- R5: Byte offset 0 in a channel group is the command byte and offset 3 is the timing byte. Both are fully writable, and each channel keeps its own copy.
- R6: Offset 1 of either group reads mode_in. A byte write there raises mode_wr for one cycle in the next cycle. mode_wdata then equals the mode_in value seen at the write, with bits 5:4 replaced by bits 5:4 of the write data.
- R7: A byte write to offset 2 (status) works bit by bit:
  - bits 6:5 are loaded from the data;
  - bit 0 is unchanged;
  - bits 2:1 are cleared where the data bit is 1 and kept where it is 0;
  - bits 7, 4 and 3 become 0.
- R8: act_set[n] sets status bit 0 of channel n, and act_clr[n] clears it unless act_set[n] is also high. err_set[n] sets bit 1 and irq_set[n] sets bit 2. A set wins over a software clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | ADDR_W | Byte address inside the window |
| acc_size | input | 2 | Access size code (0 byte, 1 half, 2/3 word) |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data byte |
| rd_data | output | 32 | Read data, one cycle after the strobe |
| rd_valid | output | 1 | Read data valid |
| desc_sel | output | NCH | Per-channel descriptor-port select |
| mode_in | input | 8 | Current value of the shared mode/mask byte |
| mode_wr | output | 1 | Update strobe to the interrupt unit |
| mode_wdata | output | 8 | Merged new mode/mask value |
| act_set | input | NCH | DMA engine sets the active bit |
| act_clr | input | NCH | DMA engine clears the active bit |
| err_set | input | NCH | DMA engine sets the error flag |
| irq_set | input | NCH | DMA engine sets the interrupt flag |
| cmd_out | output | NCH*8 | Command bytes, channel n in bits [8n+7:8n] |
| tim_out | output | NCH*8 | Timing bytes |
| sts_out | output | NCH*8 | Status bytes |

## Verification
The assertions assume that:
- the strobe inputs are never unknown after reset;
- the interrupt unit leaves mode_in steady within a cycle;
- acc_rd and acc_wr are not raised together.

The bench keeps to these assumptions. It draws at most one access per cycle and changes mode_in only at the falling edge. After each mode strobe it plays the interrupt unit and loads mode_wdata back into mode_in. The side inputs are randomised on every access, so hardware sets often coincide with software clears of the same flag.

// File: rtl/bmw_pkg.sv
package bmw_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    typedef enum logic [1:0] {
        REG_CMD  = 2'd0,
        REG_MODE = 2'd1,
        REG_STS  = 2'd2,
        REG_TIM  = 2'd3
    } reg_sel_e;

    localparam logic [7:0] STS_RW_MASK  = 8'h60;
    localparam logic [7:0] STS_W1C_MASK = 8'h06;
    localparam logic [7:0] STS_KEEP     = 8'h01;
    localparam logic [7:0] STS_ZERO     = 8'h98;
    localparam logic [7:0] MODE_SW_MASK = 8'h30;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] tim;
        logic [7:0] sts;
    } chan_regs_t;

    typedef struct packed {
        logic [31:0] rd_data;
        logic        rd_valid;
        logic        mode_wr;
        logic [7:0]  mode_wdata;
    } port_state_t;

    function automatic logic [31:0] ones_for_size(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/bmw_decode.sv
module bmw_decode
    import bmw_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = $clog2(NCH * 8)
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_rd,
    input  logic              acc_wr,
    output logic [ADDR_W-4:0] ch_idx,
    output logic              in_desc,
    output reg_sel_e          reg_sel,
    output logic              is_byte,
    output logic [NCH-1:0]    ctl_wr,
    output logic              mode_hit,
    output logic [NCH-1:0]    desc_sel
);

    localparam int CH_W = ADDR_W - 3;

    always_comb begin
        ch_idx   = acc_addr[ADDR_W-1:3];
        in_desc  = acc_addr[2];
        reg_sel  = reg_sel_e'(acc_addr[1:0]);
        is_byte  = (acc_size == SZ_BYTE);
        mode_hit = acc_wr && is_byte && !in_desc && (reg_sel == REG_MODE);
        for (int ch = 0; ch < NCH; ch++) begin
            desc_sel[ch] = (acc_rd || acc_wr) && in_desc && (ch_idx == CH_W'(ch));
            ctl_wr[ch]   = acc_wr && is_byte && !in_desc && (ch_idx == CH_W'(ch));
        end
    end

endmodule

// File: rtl/bmw_chan_regs.sv
module bmw_chan_regs
    import bmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  reg_sel_e   reg_sel,
    input  logic [7:0] wdata,
    input  logic       act_set,
    input  logic       act_clr,
    input  logic       err_set,
    input  logic       irq_set,
    output chan_regs_t regs_o
);

    chan_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_sel)
                REG_CMD: st_d.cmd = wdata;
                REG_TIM: st_d.tim = wdata;
                REG_STS: st_d.sts = (wdata & STS_RW_MASK)
                                  | (st_q.sts & STS_KEEP)
                                  | (st_q.sts & ~wdata & STS_W1C_MASK);
                default: ;
            endcase
        end
        if (act_set) begin
            st_d.sts[0] = 1'b1;
        end else if (act_clr) begin
            st_d.sts[0] = 1'b0;
        end
        if (err_set) begin
            st_d.sts[1] = 1'b1;
        end
        if (irq_set) begin
            st_d.sts[2] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q;

    AST_STS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts & STS_ZERO) == 8'h00);                                     // R7
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> st_q.sts[2]);                                            // R8
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> st_q.sts[1]);                                            // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == REG_STS && wdata[2] && !irq_set) |=> !st_q.sts[2]); // R7
    AST_ACT_SW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_set && !act_clr) |=> $stable(st_q.sts[0]));                    // R7
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(st_q.cmd) && $stable(st_q.tim)));                // R3

endmodule

// File: rtl/bmw_rd_mux.sv
module bmw_rd_mux
    import bmw_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = $clog2(NCH * 8)
) (
    input  logic [1:0]            acc_size,
    input  logic                  is_byte,
    input  logic                  in_desc,
    input  logic [ADDR_W-4:0]     ch_idx,
    input  reg_sel_e              reg_sel,
    input  chan_regs_t [NCH-1:0]  regs_i,
    input  logic [7:0]            mode_in,
    output logic [31:0]           rdata
);

    chan_regs_t sel;

    always_comb begin
        sel = regs_i[ch_idx];
        if (!is_byte) begin
            rdata = ones_for_size(acc_size);
        end else if (in_desc) begin
            rdata = 32'h0000_00FF;
        end else begin
            case (reg_sel)
                REG_CMD:  rdata = {24'h0, sel.cmd};
                REG_MODE: rdata = {24'h0, mode_in};
                REG_STS:  rdata = {24'h0, sel.sts};
                default:  rdata = {24'h0, sel.tim};
            endcase
        end
    end

endmodule

// File: rtl/bmw_window.sv
module bmw_window
    import bmw_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = $clog2(NCH * 8)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [1:0]           acc_size,
    input  logic                 acc_rd,
    input  logic                 acc_wr,
    input  logic [7:0]           acc_wdata,
    output logic [31:0]          rd_data,
    output logic                 rd_valid,
    output logic [NCH-1:0]       desc_sel,
    input  logic [7:0]           mode_in,
    output logic                 mode_wr,
    output logic [7:0]           mode_wdata,
    input  logic [NCH-1:0]       act_set,
    input  logic [NCH-1:0]       act_clr,
    input  logic [NCH-1:0]       err_set,
    input  logic [NCH-1:0]       irq_set,
    output logic [NCH*8-1:0]     cmd_out,
    output logic [NCH*8-1:0]     tim_out,
    output logic [NCH*8-1:0]     sts_out
);

    logic [ADDR_W-4:0] ch_idx;
    logic              in_desc;
    reg_sel_e          reg_sel;
    logic              is_byte;
    logic [NCH-1:0]    ctl_wr;
    logic              mode_hit;
    logic [31:0]       mux_data;

    chan_regs_t [NCH-1:0] regs;
    port_state_t          ps_d, ps_q;

    bmw_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_decode (
        .acc_addr (acc_addr),
        .acc_size (acc_size),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .ch_idx   (ch_idx),
        .in_desc  (in_desc),
        .reg_sel  (reg_sel),
        .is_byte  (is_byte),
        .ctl_wr   (ctl_wr),
        .mode_hit (mode_hit),
        .desc_sel (desc_sel)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        bmw_chan_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ctl_wr[g]),
            .reg_sel (reg_sel),
            .wdata   (acc_wdata),
            .act_set (act_set[g]),
            .act_clr (act_clr[g]),
            .err_set (err_set[g]),
            .irq_set (irq_set[g]),
            .regs_o  (regs[g])
        );
        assign cmd_out[g*8 +: 8] = regs[g].cmd;
        assign tim_out[g*8 +: 8] = regs[g].tim;
        assign sts_out[g*8 +: 8] = regs[g].sts;
    end

    bmw_rd_mux #(.NCH(NCH), .ADDR_W(ADDR_W)) u_rd_mux (
        .acc_size (acc_size),
        .is_byte  (is_byte),
        .in_desc  (in_desc),
        .ch_idx   (ch_idx),
        .reg_sel  (reg_sel),
        .regs_i   (regs),
        .mode_in  (mode_in),
        .rdata    (mux_data)
    );

    always_comb begin
        ps_d          = ps_q;
        ps_d.rd_valid = acc_rd;
        ps_d.mode_wr  = mode_hit;
        if (acc_rd) begin
            ps_d.rd_data = mux_data;
        end
        if (mode_hit) begin
            ps_d.mode_wdata = (mode_in & ~MODE_SW_MASK) | (acc_wdata & MODE_SW_MASK);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign rd_data    = ps_q.rd_data;
    assign rd_valid   = ps_q.rd_valid;
    assign mode_wr    = ps_q.mode_wr;
    assign mode_wdata = ps_q.mode_wdata;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rd_valid);                                                // R4
    AST_NO_RD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> !rd_valid);                                              // R4
    AST_WIDE_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_size[1]) |=> (rd_data == 32'hFFFF_FFFF));             // R3
    AST_MODE_KEEP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_hit |=> (mode_wr && ((mode_wdata & 8'hCF) == ($past(mode_in) & 8'hCF)))); // R6
    AST_MODE_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |-> $past(acc_wr && acc_size == SZ_BYTE && !acc_addr[2]));  // R6
    AST_DESC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(desc_sel));                                                 // R2
    AST_DESC_NO_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|desc_sel) |-> (ctl_wr == '0));                                     // R2

endmodule

// File: tb/bmw_window_tb_top.sv
module bmw_window_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int AW  = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [AW-1:0]   acc_addr;
    logic [1:0]      acc_size;
    logic            acc_rd, acc_wr;
    logic [7:0]      acc_wdata;
    logic [31:0]     rd_data;
    logic            rd_valid;
    logic [NCH-1:0]  desc_sel;
    logic [7:0]      mode_in;
    logic            mode_wr;
    logic [7:0]      mode_wdata;
    logic [NCH-1:0]  act_set, act_clr, err_set, irq_set;
    logic [NCH*8-1:0] cmd_out, tim_out, sts_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] m_cmd [NCH];
    logic [7:0] m_tim [NCH];
    logic [7:0] m_sts [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    bmw_window #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .desc_sel(desc_sel),
        .mode_in(mode_in), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .act_set(act_set), .act_clr(act_clr), .err_set(err_set), .irq_set(irq_set),
        .cmd_out(cmd_out), .tim_out(tim_out), .sts_out(sts_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input logic [1:0] sz);
        int ch = int'(a[3]);
        if (sz == 2'd1) return 32'h0000_FFFF;
        if (sz != 2'd0) return 32'hFFFF_FFFF;
        if (a[2]) return 32'h0000_00FF;
        case (a[1:0])
            2'd0:    return {24'h0, m_cmd[ch]};
            2'd1:    return {24'h0, mode_in};
            2'd2:    return {24'h0, m_sts[ch]};
            default: return {24'h0, m_tim[ch]};
        endcase
    endfunction

    // status next value from R7 and R8
    function automatic logic [7:0] exp_sts(input logic [7:0] old, input bit sw,
                                           input logic [7:0] wd, input bit as,
                                           input bit ac, input bit es, input bit is);
        logic [7:0] n = old;
        if (sw) begin
            n = 8'h00;
            n[6] = wd[6];
            n[5] = wd[5];
            n[0] = old[0];
            n[1] = old[1] && !wd[1];
            n[2] = old[2] && !wd[2];
        end
        if (as) n[0] = 1'b1;
        else if (ac) n[0] = 1'b0;
        if (es) n[1] = 1'b1;
        if (is) n[2] = 1'b1;
        return n;
    endfunction

    // one access, issued at a falling edge, checked at the next falling edge
    task automatic op(input bit rd, input bit wr, input logic [AW-1:0] a,
                      input logic [1:0] sz, input logic [7:0] wd,
                      input logic [NCH-1:0] as, input logic [NCH-1:0] ac,
                      input logic [NCH-1:0] es, input logic [NCH-1:0] is);
        logic [31:0] er;
        logic [NCH-1:0] edesc;
        bit emode;
        logic [7:0] emval;
        int ch = int'(a[3]);
        acc_rd = rd; acc_wr = wr; acc_addr = a; acc_size = sz; acc_wdata = wd;
        act_set = as; act_clr = ac; err_set = es; irq_set = is;
        #1;
        edesc = '0;
        if ((rd || wr) && a[2]) edesc[ch] = 1'b1;
        chk("R2 desc_sel", {30'h0, desc_sel}, {30'h0, edesc});
        er = exp_read(a, sz);
        emode = wr && sz == 2'd0 && !a[2] && a[1:0] == 2'd1;
        emval = (mode_in & 8'hCF) | (wd & 8'h30);
        for (int c = 0; c < NCH; c++) begin
            bit hit = wr && sz == 2'd0 && !a[2] && c == ch;
            m_sts[c] = exp_sts(m_sts[c], hit && a[1:0] == 2'd2, wd,
                               as[c], ac[c], es[c], is[c]);
            if (hit && a[1:0] == 2'd0) m_cmd[c] = wd;
            if (hit && a[1:0] == 2'd3) m_tim[c] = wd;
        end
        @(negedge clk);
        chk("R4 rd_valid", {31'h0, rd_valid}, {31'h0, rd});
        if (rd) chk("R3/R4 rd_data", rd_data, er);
        for (int c = 0; c < NCH; c++) begin
            chk("R5 cmd", {24'h0, cmd_out[c*8 +: 8]}, {24'h0, m_cmd[c]});
            chk("R5 tim", {24'h0, tim_out[c*8 +: 8]}, {24'h0, m_tim[c]});
            chk("R7/R8 sts", {24'h0, sts_out[c*8 +: 8]}, {24'h0, m_sts[c]});
        end
        chk("R6 mode_wr", {31'h0, mode_wr}, {31'h0, emode});
        if (emode) begin
            chk("R6 mode_wdata", {24'h0, mode_wdata}, {24'h0, emval});
            mode_in = mode_wdata;
        end
        acc_rd = 0; acc_wr = 0; act_set = '0; act_clr = '0; err_set = '0; irq_set = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        rst_n = 0; acc_rd = 0; acc_wr = 0; acc_addr = '0; acc_size = '0;
        acc_wdata = '0; mode_in = 8'hC5; act_set = '0; act_clr = '0;
        err_set = '0; irq_set = '0;
        for (int c = 0; c < NCH; c++) begin
            m_cmd[c] = 8'h00; m_tim[c] = 8'h00; m_sts[c] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd", {16'h0, cmd_out}, 32'h0);
        chk("R1 tim", {16'h0, tim_out}, 32'h0);
        chk("R1 sts", {16'h0, sts_out}, 32'h0);
        chk("R1 rd", rd_data, 32'h0);
        chk("R1 flags", {30'h0, rd_valid, mode_wr}, 32'h0);

        // R5 per-channel command and timing
        op(0, 1, 4'h0, 2'd0, 8'hA5, '0, '0, '0, '0);
        op(0, 1, 4'h8, 2'd0, 8'h3C, '0, '0, '0, '0);
        op(0, 1, 4'h3, 2'd0, 8'h71, '0, '0, '0, '0);
        op(0, 1, 4'hB, 2'd0, 8'h9E, '0, '0, '0, '0);
        op(1, 0, 4'h0, 2'd0, 8'h00, '0, '0, '0, '0);
        op(1, 0, 4'hB, 2'd0, 8'h00, '0, '0, '0, '0);
        // R3 wide writes ignored, wide reads all ones
        op(0, 1, 4'h0, 2'd1, 8'hFF, '0, '0, '0, '0);
        op(0, 1, 4'h8, 2'd2, 8'h00, '0, '0, '0, '0);
        op(1, 0, 4'h0, 2'd1, 8'h00, '0, '0, '0, '0);
        op(1, 0, 4'h2, 2'd2, 8'h00, '0, '0, '0, '0);
        op(1, 0, 4'hA, 2'd3, 8'h00, '0, '0, '0, '0);
        // R2 descriptor half
        op(1, 0, 4'h4, 2'd0, 8'h00, '0, '0, '0, '0);
        op(0, 1, 4'hD, 2'd0, 8'h55, '0, '0, '0, '0);
        op(1, 0, 4'hF, 2'd2, 8'h00, '0, '0, '0, '0);
        // R8 hardware sets, R7 status write rules
        op(0, 0, 4'h0, 2'd0, 8'h00, 2'b11, 2'b00, 2'b01, 2'b10);
        op(0, 1, 4'h2, 2'd0, 8'hFF, '0, '0, '0, '0);
        op(1, 0, 4'h2, 2'd0, 8'h00, '0, '0, '0, '0);
        op(0, 1, 4'hA, 2'd0, 8'h04, '0, '0, '0, 2'b10);
        op(0, 0, 4'h0, 2'd0, 8'h00, '0, 2'b01, '0, '0);
        op(0, 1, 4'hA, 2'd0, 8'h9B, 2'b00, 2'b10, 2'b10, '0);
        // R6 mode alias
        op(1, 0, 4'h1, 2'd0, 8'h00, '0, '0, '0, '0);
        op(0, 1, 4'h1, 2'd0, 8'hFF, '0, '0, '0, '0);
        mode_in = 8'h0A;
        op(0, 1, 4'h9, 2'd0, 8'hDF, '0, '0, '0, '0);
        op(1, 0, 4'h9, 2'd0, 8'h00, '0, '0, '0, '0);
        op(0, 1, 4'h1, 2'd1, 8'h30, '0, '0, '0, '0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r = $urandom;
            logic [1:0]  sz = (r[3:0] < 4'd12) ? 2'd0 : r[5:4];
            bit rdo = r[6];
            bit wro = !r[6] && r[7];
            if (r[31:28] == 4'h0) mode_in = r[27:20];
            op(rdo, wro, r[11:8], sz, r[19:12], 2'($urandom), 2'($urandom),
               2'($urandom & $urandom), 2'($urandom & $urandom));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule